// File: doc/BRIEF.md
# Receiver Automatic Gain Controller

This block is the digital half of the gain loop in a contactless reader's receive path. Two comparators outside the block report whether the demodulated envelope is above an attack level (`above_attack`) and above a lower decay level (`above_decay`). From these flags the block produces a gain step code for the programmable amplifier. Code 0 is maximum gain. Each unit of the code removes one equal share of the 40 dB correction range, up to `MAX_CODE`. When the loop is disabled, a 3-bit static gain setting drives the amplifier directly.

The gain starts at maximum, so the receiver is sensitive before a tag answers. A strong signal drives the code up (less gain) in attack steps. The code is frozen while the envelope stays above the decay level. A quiet period of a programmed length marks the end of a tag reply. After it, the gain either jumps back to maximum in one move, with a one-cycle `reply_done` pulse, or walks back one step per quiet period. An option ignores the first pulse of a burst, so that the DC level of the envelope can settle before the loop reacts.

The controller has five states:
- `ST_IDLE`: maximum gain, waiting for a reply.
- `ST_SKIP`: the first pulse of a burst is in progress and is being ignored.
- `ST_ATTACK`: gain is being reduced.
- `ST_HOLD`: the signal is above the decay level and gain is frozen.
- `ST_QUIET`: the signal is below the decay level and the quiet time is being counted.

The transitions are:
- IDLE→ATTACK: an attack flag arrives and the skip option is off.
- IDLE→SKIP: an attack flag arrives and the skip option is on.
- SKIP→HOLD or SKIP→QUIET: the first pulse ends.
- ATTACK→HOLD or ATTACK→QUIET: the attack flag drops.
- HOLD→ATTACK and QUIET→ATTACK: a new attack flag arrives.
- HOLD→QUIET: the decay flag drops.
- QUIET→HOLD: the decay flag returns.
- QUIET→IDLE: the code has come back to 0, either by fast decay or by the last slow step.
- Any state→IDLE: the loop is disabled.

Top module: `agc_ctrl`

## Requirements
- R1: With `agc_en` low, `gain_code` equals `static_gain` zero-extended, in the same cycle, whatever the flags do. The loop state is cleared, so gain is at maximum (code 0) once the loop is enabled again.
- R2: After reset `gain_code` is 0 and `reply_done` is 0. The code stays 0 while `above_attack` is low.
- R3: When the attack flag is seen while the loop is not attacking, the code rises by 1 at that clock edge. While the flag stays high, it rises by 1 more every `ATK_BASE << attack_rate` cycles, and it saturates at `MAX_CODE`.
- R4: While `above_decay` is high and `above_attack` is low, the code does not change.
- R5: With `slow_decay` low, once `above_decay` has been low for `DW_BASE << wait_sel` consecutive cycles in the quiet state, the code returns to 0. At the same edge `reply_done` goes high for exactly one cycle.
- R6: Any return of `above_decay` during the quiet time restarts the quiet count from zero.
- R7: With `slow_decay` high, the code drops by 1 for each full quiet period until it reaches 0, and `reply_done` stays low.
- R8: With `skip_first` high, an attack pulse that arrives at maximum gain in the idle state leaves the code at 0. The next attack pulse of the same burst is acted on. After a completed quiet time, the first pulse of the next burst is ignored again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| agc_en | input | 1 | Enables the gain loop |
| static_gain | input | 3 | Gain code used while the loop is disabled |
| slow_decay | input | 1 | 1 selects stepwise return to maximum gain |
| skip_first | input | 1 | 1 ignores the first pulse of a burst |
| attack_rate | input | 2 | Attack interval select, `ATK_BASE << attack_rate` cycles |
| wait_sel | input | 2 | Quiet time select, `DW_BASE << wait_sel` cycles |
| above_attack | input | 1 | Envelope is above the attack level |
| above_decay | input | 1 | Envelope is above the decay level |
| gain_code | output | CODE_W | Gain step code, 0 = maximum gain |
| reply_done | output | 1 | One-cycle pulse on a fast return to maximum gain |

## Verification
The bench builds the block with `MAX_CODE` = 5, `ATK_BASE` = 1 and `DW_BASE` = 4. With these values saturation is reached within a few attack cycles, the attack intervals are 1, 2, 4 and 8 cycles, and the quiet times are 4 to 32 cycles. That makes every attack rate, the saturation limit, a long quiet-time setting and a full slow walk from code 3 down to 0 short enough for directed cycle counts. The counts probe one cycle before and one cycle after each expected change.

// File: rtl/agc_pkg.sv
package agc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SKIP,
        ST_ATTACK,
        ST_HOLD,
        ST_QUIET
    } agc_state_t;

endpackage

// File: rtl/agc_timer.sv
module agc_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;

    assign expire = run && (cnt_q == limit - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || expire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3/R5: an interval count never passes its limit
    p_cnt_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < limit));

endmodule

// File: rtl/agc_fsm.sv
module agc_fsm
    import agc_pkg::*;
#(
    parameter int CODE_W   = 4,
    parameter int MAX_CODE = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              agc_en,
    input  logic              slow_decay,
    input  logic              skip_first,
    input  logic              above_attack,
    input  logic              above_decay,
    input  logic              atk_tick,
    input  logic              wait_tick,
    output logic              atk_run,
    output logic              wait_run,
    output logic [CODE_W-1:0] code_q,
    output logic              eor_q
);

    localparam logic [CODE_W-1:0] CODE_TOP = CODE_W'(MAX_CODE);

    agc_state_t        state_q, state_n;
    logic [CODE_W-1:0] code_n;
    logic              eor_n;
    logic [CODE_W-1:0] code_up;

    assign code_up  = (code_q == CODE_TOP) ? code_q : code_q + 1'b1;
    assign atk_run  = agc_en && (state_q == ST_ATTACK) && above_attack;
    assign wait_run = agc_en && (state_q == ST_QUIET) && !above_decay && !above_attack;

    always_comb begin
        state_n = state_q;
        code_n  = code_q;
        eor_n   = 1'b0;
        if (!agc_en) begin
            state_n = ST_IDLE;
            code_n  = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (above_attack) begin
                        if (skip_first) begin
                            state_n = ST_SKIP;
                        end else begin
                            state_n = ST_ATTACK;
                            code_n  = code_up;
                        end
                    end
                end
                ST_SKIP: begin
                    if (!above_attack) begin
                        state_n = above_decay ? ST_HOLD : ST_QUIET;
                    end
                end
                ST_ATTACK: begin
                    if (!above_attack) begin
                        state_n = above_decay ? ST_HOLD : ST_QUIET;
                    end else if (atk_tick) begin
                        code_n = code_up;
                    end
                end
                ST_HOLD: begin
                    if (above_attack) begin
                        state_n = ST_ATTACK;
                        code_n  = code_up;
                    end else if (!above_decay) begin
                        state_n = ST_QUIET;
                    end
                end
                ST_QUIET: begin
                    if (above_attack) begin
                        state_n = ST_ATTACK;
                        code_n  = code_up;
                    end else if (above_decay) begin
                        state_n = ST_HOLD;
                    end else if (wait_tick) begin
                        if (slow_decay && code_q > 1) begin
                            code_n = code_q - 1'b1;
                        end else begin
                            state_n = ST_IDLE;
                            code_n  = '0;
                            eor_n   = !slow_decay;
                        end
                    end
                end
                default: begin
                    state_n = ST_IDLE;
                    code_n  = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            eor_q  <= 1'b0;
        end else begin
            code_q <= code_n;
            eor_q  <= eor_n;
        end
    end

    p_disable_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !agc_en |=> (state_q == ST_IDLE && code_q == '0));

    p_code_saturates_r3: assert property (@(posedge clk) disable iff (!rst_n)
        code_q <= CODE_TOP);

    p_no_rise_without_attack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !above_attack |=> (code_q <= $past(code_q)));

    p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (agc_en && state_q == ST_HOLD && above_decay && !above_attack) |=> $stable(code_q));

    p_done_at_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
        eor_q |-> (code_q == '0 && state_q == ST_IDLE));

    p_decay_one_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q < $past(code_q)) |-> (code_q == '0 || code_q == $past(code_q) - 1'b1));

endmodule

// File: rtl/agc_ctrl.sv
module agc_ctrl
    import agc_pkg::*;
#(
    parameter int CODE_W   = 4,
    parameter int MAX_CODE = 10,
    parameter int ATK_BASE = 2,
    parameter int DW_BASE  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              agc_en,
    input  logic [2:0]        static_gain,
    input  logic              slow_decay,
    input  logic              skip_first,
    input  logic [1:0]        attack_rate,
    input  logic [1:0]        wait_sel,
    input  logic              above_attack,
    input  logic              above_decay,
    output logic [CODE_W-1:0] gain_code,
    output logic              reply_done
);

    localparam int AT_W = $clog2(ATK_BASE * 8 + 1);
    localparam int DW_W = $clog2(DW_BASE * 8 + 1);

    logic [AT_W-1:0]   atk_tab  [4];
    logic [DW_W-1:0]   wait_tab [4];
    logic              atk_run, wait_run, atk_tick, wait_tick;
    logic [CODE_W-1:0] loop_code;
    logic              loop_eor;

    for (genvar g = 0; g < 4; g++) begin : g_tab
        assign atk_tab[g]  = AT_W'(ATK_BASE << g);
        assign wait_tab[g] = DW_W'(DW_BASE << g);
    end

    agc_timer #(.CNT_W(AT_W)) u_atk_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (atk_run),
        .limit  (atk_tab[attack_rate]),
        .expire (atk_tick)
    );

    agc_timer #(.CNT_W(DW_W)) u_wait_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (wait_run),
        .limit  (wait_tab[wait_sel]),
        .expire (wait_tick)
    );

    agc_fsm #(.CODE_W(CODE_W), .MAX_CODE(MAX_CODE)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .agc_en       (agc_en),
        .slow_decay   (slow_decay),
        .skip_first   (skip_first),
        .above_attack (above_attack),
        .above_decay  (above_decay),
        .atk_tick     (atk_tick),
        .wait_tick    (wait_tick),
        .atk_run      (atk_run),
        .wait_run     (wait_run),
        .code_q       (loop_code),
        .eor_q        (loop_eor)
    );

    assign gain_code  = agc_en ? loop_code : CODE_W'(static_gain);
    assign reply_done = loop_eor;

endmodule

// File: tb/sim_agc_ctrl.sv
module sim_agc_ctrl;

    localparam int CW = 4;
    localparam int MAXC = 5;
    localparam int W0 = 4;

    // each row: attack_rate, cycles with attack flag high, expected code
    localparam int VEC [0:5][0:2] = '{
        '{0, 3, 3},
        '{1, 3, 2},
        '{2, 5, 2},
        '{3, 4, 1},
        '{0, 9, 5},
        '{1, 6, 3}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          agc_en = 1'b1;
    logic [2:0]    static_gain = '0;
    logic          slow_decay = 1'b0;
    logic          skip_first = 1'b0;
    logic [1:0]    attack_rate = '0;
    logic [1:0]    wait_sel = '0;
    logic          above_attack = 1'b0;
    logic          above_decay = 1'b0;
    logic [CW-1:0] gain_code;
    logic          reply_done;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    agc_ctrl #(.CODE_W(CW), .MAX_CODE(MAXC), .ATK_BASE(1), .DW_BASE(W0)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .agc_en       (agc_en),
        .static_gain  (static_gain),
        .slow_decay   (slow_decay),
        .skip_first   (skip_first),
        .attack_rate  (attack_rate),
        .wait_sel     (wait_sel),
        .above_attack (above_attack),
        .above_decay  (above_decay),
        .gain_code    (gain_code),
        .reply_done   (reply_done)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // quiet the decay flag and expect a fast return after w cycles
    task automatic fast_return(input int w, input int held, input string req);
        above_attack = 1'b0;
        above_decay  = 1'b0;
        ticks(w);
        check({req, " code before quiet time ends"}, gain_code, held);
        check({req, " no early done"}, reply_done, 0);
        ticks(1);
        check({req, " code at max"}, gain_code, 0);
        check({req, " done pulse"}, reply_done, 1);
        ticks(1);
        check({req, " done one cycle"}, reply_done, 0);
    endtask

    task automatic attack_for(input int rate, input int n);
        attack_rate  = 2'(rate);
        above_decay  = 1'b1;
        above_attack = 1'b1;
        ticks(n);
        above_attack = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        ticks(3);
        rst_n = 1'b1;
        check("R2 reset code", gain_code, 0);
        check("R2 reset done", reply_done, 0);
        above_decay = 1'b1;
        ticks(6);
        check("R2 idle without attack", gain_code, 0);

        // R3 table walk, each row followed by R4 hold and R5 fast return
        for (int i = 0; i < 6; i++) begin
            attack_for(VEC[i][0], VEC[i][1]);
            check("R3 attack steps", gain_code, VEC[i][2]);
            ticks(7);
            check("R4 hold keeps code", gain_code, VEC[i][2]);
            fast_return(W0, VEC[i][2], "R5");
        end

        // R5 longest-but-one quiet time, wait_sel=2 gives 16 cycles
        wait_sel = 2'd2;
        attack_for(3, 1);
        check("R3 single step", gain_code, 1);
        fast_return(W0 * 4, 1, "R5 sel2");
        wait_sel = 2'd0;

        // R6 quiet count restarts when the decay flag returns
        attack_for(0, 2);
        above_decay = 1'b0;
        ticks(W0);
        above_decay = 1'b1;
        ticks(1);
        check("R6 code after flag return", gain_code, 2);
        fast_return(W0, 2, "R6");

        // R7 slow walk from 3 down to 0
        attack_for(0, 3);
        slow_decay  = 1'b1;
        above_decay = 1'b0;
        ticks(W0);
        check("R7 before first step", gain_code, 3);
        ticks(1);
        check("R7 first step", gain_code, 2);
        check("R7 no done", reply_done, 0);
        ticks(W0);
        check("R7 second step", gain_code, 1);
        ticks(W0 - 1);
        check("R7 before last step", gain_code, 1);
        ticks(1);
        check("R7 at max", gain_code, 0);
        check("R7 no done at end", reply_done, 0);
        ticks(1);
        check("R7 no late done", reply_done, 0);
        slow_decay = 1'b0;

        // R8 first pulse ignored, second acted on, next burst skipped again
        skip_first = 1'b1;
        attack_rate = 2'd0;
        above_decay = 1'b1;
        above_attack = 1'b1;
        ticks(3);
        check("R8 first pulse ignored", gain_code, 0);
        above_attack = 1'b0;
        ticks(1);
        above_attack = 1'b1;
        ticks(1);
        above_attack = 1'b0;
        check("R8 second pulse attacks", gain_code, 1);
        fast_return(W0, 1, "R8");
        above_decay = 1'b1;
        above_attack = 1'b1;
        ticks(2);
        above_attack = 1'b0;
        check("R8 new burst ignored", gain_code, 0);
        above_decay = 1'b0;
        ticks(W0 + 2);
        skip_first = 1'b0;

        // R1 static pass-through and clearing on disable
        attack_for(0, 2);
        check("R3 pre-disable code", gain_code, 2);
        agc_en = 1'b0;
        static_gain = 3'd5;
        ticks(1);
        check("R1 static code", gain_code, 5);
        above_attack = 1'b1;
        static_gain = 3'd7;
        ticks(3);
        check("R1 flags ignored", gain_code, 7);
        above_attack = 1'b0;
        above_decay = 1'b0;
        agc_en = 1'b1;
        ticks(1);
        check("R1 max gain after enable", gain_code, 0);
        check("R1 no done after enable", reply_done, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule